// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank synchronous graphics memory. It takes the memory from reset to a usable state. It owns the command pins, clock enable, the byte masks and the address bus for the whole bring-up. Once the memory is ready, it hands control to the rest of the controller through a single `init_done` flag.

After reset it holds the memory quiet with NOPs for a programmable stabilisation pause. It then closes both banks with one precharge-all command, runs a configurable number of auto-refresh cycles, and programs the mode register with a value fixed at build time. The mode register powers up undefined, so this last step is mandatory.

Every gap is a parameter counted in clock cycles. The integrator derives each gap from the memory's time limit as ceil(t / tCK). The block has no data path, so there is no valid/ready interface and no back-pressure. All pins are plain control and status signals.

Top module: `sgram_init_seq`

## Requirements
- R1: While reset is asserted, `mem_cke` is 1, every `mem_dqm` bit is 1, the command is NOP and `init_done` is 0. NOP means {cs_n, ras_n, cas_n, we_n, dsf} = 0,1,1,1,0.
- R2: After reset is released, the block issues only NOPs for exactly `PAUSE_CYC` cycles. Here cycle 0 is the one before the first rising edge. The first non-NOP command appears in cycle `PAUSE_CYC`.
- R3: The first command is a precharge of both banks. It is encoded {cs_n, ras_n, cas_n, we_n, dsf} = 0,0,1,0,0, with address bit 9 at 1 and all other address bits at 0.
- R4: The first auto-refresh comes exactly `TRP_CYC` cycles after the precharge, with NOPs in between.
- R5: Exactly `NUM_REFRESH` auto-refresh commands are issued, each `TRC_CYC` cycles after the previous one, with NOPs in between. Auto-refresh is encoded {cs_n, ras_n, cas_n, we_n, dsf} = 0,0,0,1,0, with the address at 0.
- R6: The mode-register load comes exactly `TRC_CYC` cycles after the last refresh, when both banks are idle. It is encoded with all five control pins at 0, and the address bus carries `MODE_VALUE`.
- R7: `init_done` rises in the cycle right after the mode-register load and stays high. From then on the block issues only NOPs.
- R8: `mem_cke` and every `mem_dqm` bit stay at 1 in every cycle, before and after `init_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_cke | output | 1 | Clock enable to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dsf | output | 1 | Special-function select, held low by this block |
| mem_dqm | output | DQM_W | Byte masks, held high |
| mem_addr | output | ADDR_W | Address bus: precharge-all flag or mode value |
| init_done | output | 1 | Memory ready for normal traffic |

## Verification
A miscounted timer or refresh counter moves a command off its expected cycle, and the scoreboard catches this at that command. A precharge or refresh landing one cycle early or late is flagged in that same cycle, and a lost or extra refresh is flagged at the mode load. A wrong state decode gives a wrong pin pattern or address, and this is seen on the first non-NOP cycle of that state. A ready flag that rises early, late or drops again is caught within one cycle of the mode load.

// File: rtl/sgram_init_pkg.sv
package sgram_init_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRECHG,
    ST_GAP,
    ST_REFRESH,
    ST_LOADMODE,
    ST_READY
  } init_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic dsf;
  } mem_cmd_t;

  localparam mem_cmd_t CMD_NOP    = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, dsf: 1'b0};
  localparam mem_cmd_t CMD_PREALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, dsf: 1'b0};
  localparam mem_cmd_t CMD_AREF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, dsf: 1'b0};
  localparam mem_cmd_t CMD_LMODE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0, dsf: 1'b0};

  // The memory decodes address bit 9 during precharge as "all banks".
  localparam int PREALL_BIT = 9;

endpackage

// File: rtl/sgram_init_timer.sv
module sgram_init_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RST_VAL);

  logic [CNT_W-1:0] cnt_q;

  // Counts down to zero and holds there until reloaded.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= RST_CNT;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sgram_init_fsm.sv
module sgram_init_fsm
  import sgram_init_pkg::*;
#(
  parameter int NUM_REFRESH = 2,
  parameter int TRP_CYC     = 2,
  parameter int TRC_CYC     = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output init_state_e      state_q
);
  localparam int REF_W = $clog2(NUM_REFRESH + 1);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(NUM_REFRESH - 1);
  // The command cycle itself counts toward the gap, and the wait state
  // leaves as the timer reads zero, so the load is two below the gap.
  localparam logic [CNT_W-1:0] TRP_LD = CNT_W'(TRP_CYC - 2);
  localparam logic [CNT_W-1:0] TRC_LD = CNT_W'(TRC_CYC - 2);

  init_state_e      state_d, ret_q, ret_d;
  logic [REF_W-1:0] ref_q, ref_d;

  always_comb begin
    state_d  = state_q;
    ret_d    = ret_q;
    ref_d    = ref_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_PAUSE: if (tmr_zero) state_d = ST_PRECHG;
      ST_PRECHG: begin
        tmr_load = 1'b1;
        tmr_val  = TRP_LD;
        ret_d    = ST_REFRESH;
        state_d  = ST_GAP;
      end
      ST_GAP: if (tmr_zero) state_d = ret_q;
      ST_REFRESH: begin
        tmr_load = 1'b1;
        tmr_val  = TRC_LD;
        ref_d    = ref_q + 1'b1;
        ret_d    = (ref_q == REF_LAST) ? ST_LOADMODE : ST_REFRESH;
        state_d  = ST_GAP;
      end
      ST_LOADMODE: state_d = ST_READY;
      ST_READY:    state_d = ST_READY;
      default:     state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PAUSE;
      ret_q   <= ST_REFRESH;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      ref_q   <= ref_d;
    end
  end
endmodule

// File: rtl/sgram_init_cmd.sv
module sgram_init_cmd
  import sgram_init_pkg::*;
#(
  parameter int          ADDR_W     = 11,
  parameter int          DQM_W      = 4,
  parameter logic [10:0] MODE_VALUE = 11'h032
) (
  input  init_state_e       state_q,
  output logic              mem_cke,
  output mem_cmd_t          cmd,
  output logic [DQM_W-1:0]  mem_dqm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);
  localparam logic [ADDR_W-1:0] ADDR_PREALL = ADDR_W'(1) << PREALL_BIT;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = ADDR_W'(MODE_VALUE);

  always_comb begin
    cmd       = CMD_NOP;
    mem_addr  = '0;
    init_done = 1'b0;
    unique case (state_q)
      ST_PRECHG: begin
        cmd      = CMD_PREALL;
        mem_addr = ADDR_PREALL;
      end
      ST_REFRESH: cmd = CMD_AREF;
      ST_LOADMODE: begin
        cmd      = CMD_LMODE;
        mem_addr = ADDR_MODE;
      end
      ST_READY: init_done = 1'b1;
      default: ;
    endcase
  end

  assign mem_cke = 1'b1;

  // The masks stay high per byte lane; the controller takes them over after ready.
  for (genvar b = 0; b < DQM_W; b++) begin : g_mask
    assign mem_dqm[b] = 1'b1;
  end
endmodule

// File: rtl/sgram_init_seq.sv
module sgram_init_seq
  import sgram_init_pkg::*;
#(
  parameter int          PAUSE_CYC   = 20000,
  parameter int          TRP_CYC     = 3,
  parameter int          TRC_CYC     = 7,
  parameter int          NUM_REFRESH = 2,
  parameter int          ADDR_W      = 11,
  parameter int          DQM_W       = 4,
  parameter logic [10:0] MODE_VALUE  = 11'h032
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_dsf,
  output logic [DQM_W-1:0]  mem_dqm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);
  // Values below the sequence's floor are raised to it.
  localparam int PAUSE_EFF = (PAUSE_CYC < 1) ? 1 : PAUSE_CYC;
  localparam int TRP_EFF   = (TRP_CYC < 2) ? 2 : TRP_CYC;
  localparam int TRC_EFF   = (TRC_CYC < 2) ? 2 : TRC_CYC;
  localparam int NREF_EFF  = (NUM_REFRESH < 2) ? 2 : NUM_REFRESH;
  localparam int GAP_MAX   = (TRP_EFF > TRC_EFF) ? TRP_EFF : TRC_EFF;
  localparam int CNT_MAX   = (PAUSE_EFF > GAP_MAX) ? PAUSE_EFF : GAP_MAX;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  init_state_e      state_q;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  mem_cmd_t         cmd;

  sgram_init_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(PAUSE_EFF - 1)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  sgram_init_fsm #(
    .NUM_REFRESH(NREF_EFF),
    .TRP_CYC    (TRP_EFF),
    .TRC_CYC    (TRC_EFF),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_zero(tmr_zero),
    .tmr_load(tmr_load),
    .tmr_val (tmr_val),
    .state_q (state_q)
  );

  sgram_init_cmd #(
    .ADDR_W    (ADDR_W),
    .DQM_W     (DQM_W),
    .MODE_VALUE(MODE_VALUE)
  ) u_cmd (
    .state_q  (state_q),
    .mem_cke  (mem_cke),
    .cmd      (cmd),
    .mem_dqm  (mem_dqm),
    .mem_addr (mem_addr),
    .init_done(init_done)
  );

  assign mem_cs_n  = cmd.cs_n;
  assign mem_ras_n = cmd.ras_n;
  assign mem_cas_n = cmd.cas_n;
  assign mem_we_n  = cmd.we_n;
  assign mem_dsf   = cmd.dsf;
endmodule

// File: rtl/sgram_init_chk.sv
module sgram_init_chk #(
  parameter int          TRP_CYC     = 3,
  parameter int          TRC_CYC     = 7,
  parameter int          NUM_REFRESH = 2,
  parameter int          ADDR_W      = 11,
  parameter int          DQM_W       = 4,
  parameter logic [10:0] MODE_VALUE  = 11'h032
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_cke,
  input logic              mem_cs_n,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_we_n,
  input logic              mem_dsf,
  input logic [DQM_W-1:0]  mem_dqm,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              init_done
);
  localparam int TRP_EFF = (TRP_CYC < 2) ? 2 : TRP_CYC;
  localparam int TRC_EFF = (TRC_CYC < 2) ? 2 : TRC_CYC;
  localparam int NREF    = (NUM_REFRESH < 2) ? 2 : NUM_REFRESH;
  localparam int GMAX    = ((TRP_EFF > TRC_EFF) ? TRP_EFF : TRC_EFF) + 1;
  localparam int GW      = $clog2(GMAX + 1);
  localparam int RW      = $clog2(NREF + 2);
  localparam logic [GW-1:0] TRP_G  = GW'(TRP_EFF);
  localparam logic [GW-1:0] TRC_G  = GW'(TRC_EFF);
  localparam logic [GW-1:0] GMAX_G = GW'(GMAX);
  localparam logic [RW-1:0] NREF_R = RW'(NREF);
  localparam logic [ADDR_W-1:0] PRE_A  = ADDR_W'(1) << 9;
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_VALUE);

  logic [4:0] pins;
  logic       is_nop, is_pre, is_ref, is_mrs;
  assign pins   = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf};
  assign is_nop = (pins == 5'b01110);
  assign is_pre = (pins == 5'b00100);
  assign is_ref = (pins == 5'b00010);
  assign is_mrs = (pins == 5'b00000);

  // Distance since the last non-NOP command and the kind of that command.
  logic [GW-1:0] gap_q;
  logic          last_pre_q, last_ref_q;
  logic [RW-1:0] ref_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q      <= '0;
      last_pre_q <= 1'b0;
      last_ref_q <= 1'b0;
      ref_seen_q <= '0;
    end else begin
      if (!is_nop) begin
        gap_q      <= GW'(1);
        last_pre_q <= is_pre;
        last_ref_q <= is_ref;
      end else if (gap_q != GMAX_G && gap_q != '0) begin
        gap_q <= gap_q + 1'b1;
      end
      if (is_ref && ref_seen_q != '1) ref_seen_q <= ref_seen_q + 1'b1;
    end
  end

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke && (&mem_dqm));

  // R3
  pre_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> mem_addr == PRE_A);

  // R4
  pre_to_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && last_pre_q) |-> gap_q == TRP_G);

  // R5
  ref_to_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && last_ref_q) |-> gap_q == TRC_G);

  // R5
  ref_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> ref_seen_q == NREF_R);

  // R6
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (mem_addr == MODE_A && last_ref_q && gap_q == TRC_G));

  // R7
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |=> init_done);

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop);
endmodule

bind sgram_init_seq sgram_init_chk #(
  .TRP_CYC    (TRP_CYC),
  .TRC_CYC    (TRC_CYC),
  .NUM_REFRESH(NUM_REFRESH),
  .ADDR_W     (ADDR_W),
  .DQM_W      (DQM_W),
  .MODE_VALUE (MODE_VALUE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_cke  (mem_cke),
  .mem_cs_n (mem_cs_n),
  .mem_ras_n(mem_ras_n),
  .mem_cas_n(mem_cas_n),
  .mem_we_n (mem_we_n),
  .mem_dsf  (mem_dsf),
  .mem_dqm  (mem_dqm),
  .mem_addr (mem_addr),
  .init_done(init_done)
);

// File: tb/sgram_init_seq_bench.sv
module sgram_init_seq_bench;
  localparam int          P_PAUSE = 20000;
  localparam int          P_TRP   = 3;
  localparam int          P_TRC   = 7;
  localparam int          P_NREF  = 3;
  localparam logic [10:0] P_MODE  = 11'h027;
  localparam int MRS_K  = P_PAUSE + P_TRP + P_NREF * P_TRC;
  localparam int DONE_K = MRS_K + 1;
  localparam int END_K  = DONE_K + 80;

  localparam logic [4:0] NOP = 5'b01110;
  localparam logic [4:0] PRE = 5'b00100;
  localparam logic [4:0] REF = 5'b00010;
  localparam logic [4:0] MRS = 5'b00000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf;
  logic [3:0]  mem_dqm;
  logic [10:0] mem_addr;
  logic        init_done;

  always #5 clk = ~clk;

  sgram_init_seq #(
    .PAUSE_CYC  (P_PAUSE),
    .TRP_CYC    (P_TRP),
    .TRC_CYC    (P_TRC),
    .NUM_REFRESH(P_NREF),
    .ADDR_W     (11),
    .DQM_W      (4),
    .MODE_VALUE (P_MODE)
  ) u_sgram_init_seq (
    .clk(clk), .rst_n(rst_n), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_dsf(mem_dsf), .mem_dqm(mem_dqm), .mem_addr(mem_addr),
    .init_done(init_done)
  );

  typedef struct {
    int          at;
    logic [4:0]  cmd;
    logic [10:0] addr;
    string       req;
  } exp_t;

  exp_t sb[$];
  int   total = 0;
  int   bad = 0;
  bit   finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: expected command schedule, from the requirements.
  task automatic plan_schedule();
    exp_t e;
    e.at = P_PAUSE; e.cmd = PRE; e.addr = 11'h200; e.req = "R3 precharge-all";
    sb.push_back(e);
    for (int i = 0; i < P_NREF; i++) begin
      e.at   = P_PAUSE + P_TRP + i * P_TRC;
      e.cmd  = REF;
      e.addr = 11'h000;
      e.req  = (i == 0) ? "R4 first refresh" : "R5 refresh";
      sb.push_back(e);
    end
    e.at = MRS_K; e.cmd = MRS; e.addr = P_MODE; e.req = "R6 mode load";
    sb.push_back(e);
  endtask

  // Monitor: one sample per cycle, away from the rising edge.
  task automatic monitor_run();
    int  hold_err = 0;
    int  drop_err = 0;
    bit  seen_done = 0;
    for (int k = 0; k <= END_K; k++) begin
      logic [4:0] pins;
      pins = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf};
      if (!mem_cke || mem_dqm != 4'hF) hold_err++;
      if (init_done && !seen_done) begin
        seen_done = 1;
        check(k == DONE_K, "R7 ready cycle", k, DONE_K);
      end
      if (seen_done && !init_done) drop_err++;
      if (pins != NOP) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7 command after ready", int'(pins), int'(NOP));
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(k == e.at, {e.req, " cycle"}, k, e.at);
          check(pins == e.cmd, {e.req, " pins"}, int'(pins), int'(e.cmd));
          check(mem_addr == e.addr, {e.req, " addr"}, int'(mem_addr), int'(e.addr));
        end
      end
      @(negedge clk);
    end
    check(hold_err == 0, "R8 cke/dqm held", hold_err, 0);
    check(drop_err == 0, "R7 ready stays high", drop_err, 0);
    check(seen_done, "R7 ready seen", int'(seen_done), 1);
    check(sb.size() == 0, "R5 all commands issued", sb.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(mem_cke == 1'b1, "R1 cke in reset", int'(mem_cke), 1);
    check(mem_dqm == 4'hF, "R1 dqm in reset", int'(mem_dqm), 15);
    check({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf} == NOP, "R1 NOP in reset",
          int'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf}), int'(NOP));
    check(init_done == 1'b0, "R1 ready low in reset", int'(init_done), 0);
    plan_schedule();
    rst_n = 1'b1;
    #1;
    // R2: the pause is verified by the precharge landing exactly at cycle PAUSE_CYC.
    monitor_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (END_K + 2000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule